// File: doc/BRIEF.md
# Programmable Counter Timebase Selector

This block is a 16-bit free-running counter whose rate of advance comes from one of eight tick sources. A byte-wide mode register selects the source. The sources are:

- two fixed prescalers on the system clock;
- every system clock;
- three single-cycle overflow pulses from neighbouring timers;
- falling edges on an external count pin;
- an external clock, synchronized and then divided by eight.

The mode register also decides whether counting pauses while the CPU is idle, and it masks the overflow interrupt.

Software reaches the block through a small register port. The port has a 2-bit address, a write strobe, write data and combinational read data. Address 0 is the mode byte, address 1 is the low count byte, address 2 is the high count byte, and address 3 is the status byte. The counter runs only while the run-enable input is high. When it wraps, a sticky overflow flag is raised, and software clears the flag through the status byte.

Top module: `tbase_counter`

## Requirements
- R1: After reset the mode byte reads 0x00, the count is 0x0000, and both the overflow flag and the interrupt request are low.
- R2: The mode byte sits at address 0. Its bits 6:4 always read as 0, and writing ones to them has no effect. Bits 7, 3:1 and 0 read back what was written.
- R3: Mode bits 3:1 pick the tick source. Code 000 advances the count once every 12 system clocks, 001 once every 4 system clocks, and 100 on every system clock.
- R4: Code 010 advances the count once per pulse on `tmr_a_ovf`, 110 once per pulse on `tmr_b_ovf`, and 111 once per pulse on `tmr_c_ovf`.
- R5: Code 011 advances the count once per high-to-low transition of `cnt_pin`, after synchronization. Low-to-high transitions do not count.
- R6: Code 101 advances the count once per eight synchronized rising edges of `ext_clk`.
- R7: While `run_en` is low, the count does not change.
- R8: With mode bit 7 at 1, the count holds while `cpu_idle` is high. With bit 7 at 0, `cpu_idle` has no effect.
- R9: A tick at count 0xFFFF wraps the count to 0x0000 and sets the overflow flag, which reads as bit 0 at address 3. The flag stays set until a write to address 3 with bit 0 at 0.
- R10: `irq` is high exactly when mode bit 0 is 1 and the overflow flag is set.
- R11: A write to address 1 or 2 loads that count byte, and the written value wins over a tick in the same cycle.
- R12: A write that changes the source code restarts the prescaler. With code 000 written in cycle E0, the first tick lands 12 clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable |
| cpu_idle | input | 1 | CPU is in idle |
| tmr_a_ovf | input | 1 | Overflow pulse, timer A |
| tmr_b_ovf | input | 1 | Overflow pulse, timer B |
| tmr_c_ovf | input | 1 | Overflow pulse, timer C |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| ext_clk | input | 1 | External clock (asynchronous) |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the count advance over a 96-cycle window for every source code while periodic stimulus runs in the background. A wrong decode of the source code or a wrong prescaler divisor shows up as a wrong delta. A falling-edge detector that fires on the wrong polarity still counts the same number of edges, so the pin stimulus keeps distinct high and low times. A divide-by-8 stage with an off-by-one terminal count gives a wrong tick total over the window.

Directed cases cover five points:
- A tick in the same cycle as a byte write must not add one to the written value.
- A wrap from 0xFFFF must clear the count and set the flag, and `irq` must follow the mask bit.
- A source change must restart the prescaler so the first tick lands after exactly 12 clocks.
- The idle gate must act only when mode bit 7 is set.
- The unused mode bits must read as zero after a write of all ones.

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int EXT_DIV  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic        cpu_idle,
  input  logic        tmr_a_ovf,
  input  logic        tmr_b_ovf,
  input  logic        tmr_c_ovf,
  input  logic        cnt_pin,
  input  logic        ext_clk,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [15:0] count,
  output logic        ovf_flag,
  output logic        irq
);
  localparam int PW = $clog2(DIV_SLOW > DIV_FAST ? DIV_SLOW : DIV_FAST);
  localparam int EW = $clog2(EXT_DIV);

  localparam logic [2:0] SRC_SLOW = 3'd0;
  localparam logic [2:0] SRC_FAST = 3'd1;
  localparam logic [2:0] SRC_TA   = 3'd2;
  localparam logic [2:0] SRC_PIN  = 3'd3;
  localparam logic [2:0] SRC_SYS  = 3'd4;
  localparam logic [2:0] SRC_EXT  = 3'd5;
  localparam logic [2:0] SRC_TB   = 3'd6;
  localparam logic [2:0] SRC_TC   = 3'd7;

  logic          idle_gate, irq_en;
  logic [2:0]    src;
  logic [PW-1:0] pre;
  logic [EW-1:0] ediv;
  logic [2:0]    pin_s, eclk_s;
  logic          tick, adv;

  wire mode_wr = reg_wr && reg_addr == 2'd0;
  wire lo_wr   = reg_wr && reg_addr == 2'd1;
  wire hi_wr   = reg_wr && reg_addr == 2'd2;
  wire st_wr   = reg_wr && reg_addr == 2'd3;
  wire cnt_wr  = lo_wr || hi_wr;
  wire src_chg = mode_wr && reg_wdata[3:1] != src;
  wire unused_mode_bits = ^reg_wdata[6:4];

  wire [PW-1:0] pre_last = (src == SRC_FAST) ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  wire pre_tick  = pre == pre_last;
  wire pin_fall  = pin_s[2] & ~pin_s[1];
  wire eclk_rise = ~eclk_s[2] & eclk_s[1];
  wire ext_tick  = eclk_rise && ediv == EW'(EXT_DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_gate <= 1'b0;
      src       <= SRC_SLOW;
      irq_en    <= 1'b0;
    end else if (mode_wr) begin
      idle_gate <= reg_wdata[7];
      src       <= reg_wdata[3:1];
      irq_en    <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || src_chg || pre_tick) pre <= '0;
    else                               pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s  <= '0;
      eclk_s <= '0;
      ediv   <= '0;
    end else begin
      pin_s  <= {pin_s[1:0], cnt_pin};
      eclk_s <= {eclk_s[1:0], ext_clk};
      if (eclk_rise) ediv <= ediv + 1'b1;
    end
  end

  always_comb begin
    case (src)
      SRC_SLOW, SRC_FAST: tick = pre_tick;
      SRC_TA:             tick = tmr_a_ovf;
      SRC_PIN:            tick = pin_fall;
      SRC_SYS:            tick = 1'b1;
      SRC_EXT:            tick = ext_tick;
      SRC_TB:             tick = tmr_b_ovf;
      SRC_TC:             tick = tmr_c_ovf;
      default:            tick = 1'b0;
    endcase
  end

  assign adv = run_en && tick && !(idle_gate && cpu_idle);
  wire wrap = adv && !cnt_wr && count == 16'hFFFF;

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (lo_wr)  count <= {count[15:8], reg_wdata};
    else if (hi_wr)  count <= {reg_wdata, count[7:0]};
    else if (adv)    count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ovf_flag <= 1'b0;
    else if (wrap)                   ovf_flag <= 1'b1;
    else if (st_wr && !reg_wdata[0]) ovf_flag <= 1'b0;
  end

  assign irq = irq_en & ovf_flag;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {idle_gate, 3'b000, src, irq_en};
      2'd1:    reg_rdata = count[7:0];
      2'd2:    reg_rdata = count[15:8];
      default: reg_rdata = {7'b0, ovf_flag};
    endcase
  end

  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reg_wr) |=> $stable(count));
  assert_idle_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_gate && cpu_idle && !reg_wr) |=> $stable(count));
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (count == $past(count) || count == $past(count) + 16'd1));
  assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 16'hFFFF && adv && !reg_wr) |=> (ovf_flag && count == 16'h0000));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !st_wr) |=> ovf_flag);
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> count[7:0] == $past(reg_wdata));
  assert_prescale_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> pre == '0);
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

// File: tb/tbase_counter_tb.sv
module tbase_counter_tb_top;
  logic clk = 0, rst_n = 0, run_en = 0, cpu_idle = 0;
  logic tmr_a_ovf = 0, tmr_b_ovf = 0, tmr_c_ovf = 0, cnt_pin = 0, ext_clk = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [15:0] count;
  logic ovf_flag, irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tbase_counter dut_i (.*);

  always @(negedge clk) begin
    cyc++;
    tmr_a_ovf <= (cyc % 2) == 0;
    tmr_b_ovf <= (cyc % 3) == 0;
    tmr_c_ovf <= (cyc % 4) == 0;
    cnt_pin   <= (cyc % 8) < 3;
    ext_clk   <= (cyc % 4) < 2;
  end

  // source code and expected delta over a 96-cycle window
  localparam int WIN = 96;
  localparam int VEC_SRC [8] = '{0, 1, 4, 2, 6, 7, 3, 5};
  localparam int VEC_EXP [8] = '{8, 24, 96, 48, 32, 24, 12, 3};

  function automatic string tag(int s);
    case (s)
      0, 1, 4: return "R3";
      2, 6, 7: return "R4";
      3:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic window_delta(output int d);
    logic [15:0] c0;
    c0 = count;
    repeat (WIN) @(negedge clk);
    d = 16'(count - c0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, r); check("R1", r, 8'h00);
    check("R1", count, 0);
    check("R1", ovf_flag, 0);
    check("R1", irq, 0);

    // R2 unused bits
    wr(0, 8'hFF); rd(0, r); check("R2", r, 8'h8F);
    wr(0, 8'h00); rd(0, r); check("R2", r, 8'h00);

    // table walk: R3 R4 R5 R6
    run_en = 1;
    for (int i = 0; i < 8; i++) begin
      wr(0, 8'(VEC_SRC[i] << 1));
      repeat (40) @(negedge clk);
      window_delta(d);
      check(tag(VEC_SRC[i]), d, VEC_EXP[i]);
    end

    // R7 run_en low
    wr(0, 8'h08);
    run_en = 0; @(negedge clk);
    window_delta(d); check("R7", d, 0);
    run_en = 1;

    // R8 idle gating
    cpu_idle = 1;
    wr(0, 8'h88); window_delta(d); check("R8", d, 0);
    wr(0, 8'h08); window_delta(d); check("R8", d, WIN);
    cpu_idle = 0;
    wr(0, 8'h88); window_delta(d); check("R8", d, WIN);

    // R11 write wins over tick
    wr(0, 8'h08);
    wr(1, 8'h10); check("R11", count[7:0], 8'h10);
    wr(2, 8'hA5); check("R11", count[15:8], 8'hA5);

    // R9 / R10 wrap and flag
    run_en = 0;
    wr(0, 8'h09); wr(1, 8'hFF); wr(2, 8'hFF);
    check("R9", ovf_flag, 0);
    check("R10", irq, 0);
    run_en = 1; @(negedge clk); run_en = 0;
    check("R9", count, 16'h0000);
    check("R9", ovf_flag, 1);
    check("R10", irq, 1);
    wr(0, 8'h08); check("R10", irq, 0);
    wr(3, 8'h01); check("R9", ovf_flag, 1);
    wr(3, 8'h00); check("R9", ovf_flag, 0);

    // R12 prescaler restart on source change
    wr(1, 8'h00); wr(2, 8'h00);
    wr(0, 8'h02);
    wr(0, 8'h00);
    run_en = 1;
    repeat (11) @(negedge clk);
    check("R12", count, 0);
    @(negedge clk);
    check("R12", count, 1);

    done = 1;
    finish_run();
  end
endmodule